// File: doc/BRIEF.md
# Pin Controller with Interrupt Sensing

This block is a memory-mapped controller for up to 32 general-purpose pins. Software reaches it through a plain 32-bit register port with separate read and write strobes. Each pin is configured on its own in one of three ways:

- a general input,
- a general output, which drives an output-enable and a data line to the pad,
- an interrupt input.

An interrupt input senses either a level or an edge. Its polarity is selected separately.

Every input is brought into the clock domain through a two-flop synchroniser before it is read back or sensed. For each pin the block keeps a pending bit and an enable bit. Enables are cleared through one register and set through another. Pending bits are cleared by writing ones to a clear register. All pins that are pending, enabled and in interrupt mode are combined into one registered interrupt line.

A typical driver takes the interrupt, reads the status word, and clears and services the lowest set bit first. It repeats this until the status reads zero. The word at 0x28 is a storage-only setting.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, `pin_oe` and `pin_out` are zero and `irq_o` is low. All pins are then general inputs with positive polarity, level sense and masked interrupts.
- R2: The register at 0x08 drives `pin_out` at all times, including while a pin is an input. A value written there before a pin becomes an output appears on the pin in the cycle after the write.
- R3: `pin_oe[i]` is 1 one cycle after bit i of 0x04 (direction, 1 = output) is 1 and bit i of 0x00 (mode, 1 = interrupt input) is 0. A pin in interrupt mode never drives.
- R4: Reading 0x0C returns the pin levels after a two-flop synchroniser. A change at the pin is visible to a read issued two clock edges later. Read data appears one cycle after the read strobe.
- R5: In level mode (bit of 0x24 = 0), the pending bit tracks the active level every cycle. The active level is high when the polarity bit at 0x20 is 0 and low when it is 1. A clear cannot hold the bit low while the level stays active.
- R6: In edge mode (bit of 0x24 = 1), a rising edge (polarity 0) or a falling edge (polarity 1) sets the pending bit. The bit then stays set until a 1 is written to that bit of 0x14. Writing 0 there has no effect.
- R7: When a clear and a new edge on the same pin land in the same cycle, the pin stays pending.
- R8: `irq_o` is the registered OR, over all pins, of pending AND enabled AND interrupt mode. Writing a word to 0x18 disables every pin whose bit is 0 and leaves the other pins unchanged. Writing 1s to 0x1C enables those pins. Reading 0x18 returns the enable vector.
- R9: Pins in general mode never become pending. Leaving interrupt mode drops a pin's pending bit.
- R10: The word at 0x28 stores and reads back its value and has no effect on sensing or outputs.
- R11: Writes to 0x0C and 0x10 are ignored. Reads of 0x14, 0x1C and unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Output enable to the pads |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write that lands on the same clock edge as a freshly detected edge on a pin that is already pending. The edge only reaches the detector after the synchroniser delay, so the stimulus first leaves the pin pending from an earlier edge and returns the pin to its inactive level. It then toggles the pin at a falling clock edge and issues the clear write exactly two cycles later, so that both take effect together. A sweep then runs every polarity and sense combination against computed pin-word pairs. For each one, the expected status word and interrupt line are derived arithmetically from the two patterns and the enable mask.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_AW = 6;
  localparam int unsigned BUS_DW = 32;

  // word index = byte address / 4; the numbering is fixed for software
  typedef enum logic [3:0] {
    RG_MODE   = 4'd0,
    RG_DIR    = 4'd1,
    RG_DOUT   = 4'd2,
    RG_DIN    = 4'd3,
    RG_STAT   = 4'd4,
    RG_ACK    = 4'd5,
    RG_MASKW  = 4'd6,
    RG_UNMASK = 4'd7,
    RG_POL    = 4'd8,
    RG_TRIG   = 4'd9,
    RG_FILT   = 4'd10
  } reg_id_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] act;
  logic [W-1:0] prev_act;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp;
  end

  assign act      = smp ^ pol;
  assign prev_act = prev_q ^ pol;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit;
    assign hit = act[i] & ~prev_act[i];

    always_ff @(posedge clk) begin
      if (rst || !mode[i]) pend[i] <= 1'b0;
      else if (!trig[i])   pend[i] <= act[i];
      else                 pend[i] <= (pend[i] & ~clr[i]) | hit;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      pend,
  output logic [W-1:0]      mode,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      trig,
  output logic [W-1:0]      en,
  output logic [W-1:0]      clr
);
  logic [3:0]        idx;
  logic [W-1:0]      wv;
  logic [W-1:0]      filt;
  logic [BUS_DW-1:0] rd_nxt;

  assign idx = bus_addr[BUS_AW-1:2];
  assign wv  = bus_wdata[W-1:0];
  assign clr = (bus_wr && idx == RG_ACK) ? wv : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      dir  <= '0;
      dout <= '0;
      pol  <= '0;
      trig <= '0;
      en   <= '0;
      filt <= '0;
    end else if (bus_wr) begin
      case (idx)
        RG_MODE:   mode <= wv;
        RG_DIR:    dir  <= wv;
        RG_DOUT:   dout <= wv;
        RG_MASKW:  en   <= en & wv;
        RG_UNMASK: en   <= en | wv;
        RG_POL:    pol  <= wv;
        RG_TRIG:   trig <= wv;
        RG_FILT:   filt <= wv;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (idx)
      RG_MODE:  rd_nxt[W-1:0] = mode;
      RG_DIR:   rd_nxt[W-1:0] = dir;
      RG_DOUT:  rd_nxt[W-1:0] = dout;
      RG_DIN:   rd_nxt[W-1:0] = din;
      RG_STAT:  rd_nxt[W-1:0] = pend;
      RG_MASKW: rd_nxt[W-1:0] = en;
      RG_POL:   rd_nxt[W-1:0] = pol;
      RG_TRIG:  rd_nxt[W-1:0] = trig;
      RG_FILT:  rd_nxt[W-1:0] = filt;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_o
);
  logic [NPINS-1:0] smp_w, mode_w, dir_w, dout_w, pol_w, trig_w, en_w, clr_w, pend_w;
  logic [NPINS-1:0] oe_q;
  logic             irq_q;

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(smp_w)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din(smp_w), .pend(pend_w), .mode(mode_w), .dir(dir_w), .dout(dout_w),
    .pol(pol_w), .trig(trig_w), .en(en_w), .clr(clr_w)
  );

  gpio_sense #(.W(NPINS)) u_sense (
    .clk(clk), .rst(rst), .smp(smp_w), .mode(mode_w), .pol(pol_w),
    .trig(trig_w), .clr(clr_w), .pend(pend_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      oe_q  <= dir_w & ~mode_w;
      irq_q <= |(pend_w & en_w & mode_w);
    end
  end

  assign pin_out = dout_w;
  assign pin_oe  = oe_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         irq_o,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] mode,
  input logic [W-1:0] trig,
  input logic [W-1:0] pend,
  input logic [W-1:0] clr,
  input logic [W-1:0] en
);
  // R8: the interrupt line is low in the cycle after reset
  a_r8_reset_quiet: assert property (@(posedge clk) rst |=> !irq_o);

  // R8: with every pin disabled, no request follows
  a_r8_all_masked: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq_o);

  // R8: a request is backed by an enabled pending pin one cycle earlier
  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(pend & en)));

  // R3: a pin in interrupt mode is never driven
  a_r3_int_no_drive: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_oe & $past(mode)) == '0));

  // R6: an edge-mode pending bit holds unless cleared
  a_r6_edge_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend & trig & mode & ~clr) & trig & mode & ~pend) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(NPINS)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .pin_oe(pin_oe), .mode(mode_w),
  .trig(trig_w), .pend(pend_w), .clr(clr_w), .en(en_w)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/100ps
module sim_gpio_irq_ctrl;
  localparam int N = 8;
  localparam logic [5:0] A_MODE = 6'h00, A_DIR = 6'h04, A_DOUT = 6'h08,
    A_DIN = 6'h0C, A_STAT = 6'h10, A_ACK = 6'h14, A_MASK = 6'h18,
    A_UNM = 6'h1C, A_POL = 6'h20, A_TRIG = 6'h24, A_FILT = 6'h28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic irq_o;
  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [N-1:0] a, b, expp, m;
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    chk("R1 oe", 32'(pin_oe), 0);
    chk("R1 out", 32'(pin_out), 0);
    chk("R1 irq", 32'(irq_o), 0);
    foreach (v[k]) begin end
    rd(A_MODE, v); chk("R1 mode", v, 0);
    rd(A_DIR, v);  chk("R1 dir", v, 0);
    rd(A_DOUT, v); chk("R1 dout", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_MASK, v); chk("R1 enable", v, 0);
    rd(A_POL, v);  chk("R1 pol", v, 0);
    rd(A_TRIG, v); chk("R1 trig", v, 0);
    rd(A_FILT, v); chk("R1 filt", v, 0);

    // R2 output data held while input, visible immediately
    wr(A_DOUT, 32'hA5);
    chk("R2 out while input", 32'(pin_out), 32'hA5);
    chk("R2 no drive yet", 32'(pin_oe), 0);
    wr(A_DIR, 32'h3C);
    step(1);
    chk("R3 oe from dir", 32'(pin_oe), 32'h3C);
    chk("R2 out after dir", 32'(pin_out), 32'hA5);
    // R3 interrupt mode suppresses drive
    wr(A_MODE, 32'h0C);
    step(1);
    chk("R3 int mode no drive", 32'(pin_oe), 32'h30);
    wr(A_MODE, 0); wr(A_DIR, 0);

    // R4 synchronised read-back
    for (int i = 0; i < 8; i++) begin
      a = N'(i * 53 + 7);
      pin_in = a;
      step(2);
      rd(A_DIN, v);
      chk("R4 din", v, 32'(a));
    end

    // R11 read-only and write-only words
    wr(A_DIN, 32'hFF); wr(A_STAT, 32'hFF);
    rd(A_DIN, v);  chk("R11 din write ignored", v, 32'(a));
    rd(A_STAT, v); chk("R11 stat write ignored", v, 0);
    rd(A_ACK, v);  chk("R11 ack reads 0", v, 0);
    rd(A_UNM, v);  chk("R11 unmask reads 0", v, 0);
    rd(6'h30, v);  chk("R11 unmapped reads 0", v, 0);

    // R8 masked after reset: level-high pending but no request
    pin_in = '1;
    wr(A_MODE, 32'hFF);
    step(4);
    rd(A_STAT, v); chk("R5 level pending", v, 32'hFF);
    chk("R8 reset masked", 32'(irq_o), 0);
    wr(A_UNM, 32'h81); step(2);
    chk("R8 unmask raises", 32'(irq_o), 1);
    wr(A_MASK, 32'hF0);
    rd(A_MASK, v); chk("R8 mask zero bits", v, 32'h80);
    wr(A_UNM, 32'h03);
    rd(A_MASK, v); chk("R8 unmask ones", v, 32'h83);
    // R5 clear cannot hold a level
    wr(A_ACK, 32'hFF); step(1);
    rd(A_STAT, v); chk("R5 clear vs level", v, 32'hFF);
    // R9 general pins never pend; leaving interrupt mode drops pending
    wr(A_MODE, 32'h0F); step(1);
    rd(A_STAT, v); chk("R9 mixed modes", v, 32'h0F);
    // R10 filter word stores, no effect
    wr(A_FILT, 32'h5A);
    rd(A_FILT, v); chk("R10 filt readback", v, 32'h5A);
    step(3);
    rd(A_STAT, v); chk("R10 no effect", v, 32'h0F);
    wr(A_FILT, 0);

    // sweep: every polarity/sense over computed pin pairs
    wr(A_MODE, 32'hFF);
    for (int t = 0; t < 4; t++) begin
      logic p, e;
      p = t[0]; e = t[1];
      wr(A_POL, p ? 32'hFF : 0);
      wr(A_TRIG, e ? 32'hFF : 0);
      for (int i = 0; i < 16; i++) begin
        a = N'(i * 37 + t);
        b = N'(i * 91 + 5);
        m = N'(i * 29 + 3);
        pin_in = a; step(4);
        wr(A_ACK, 32'hFF); step(2);
        wr(A_MASK, 0); wr(A_UNM, 32'(m));
        pin_in = b; step(4);
        if (!e) expp = p ? ~b : b;
        else    expp = p ? (a & ~b) : (b & ~a);
        rd(A_STAT, v);
        chk(e ? "R6 edge sweep" : "R5 level sweep", v, 32'(expp));
        step(1);
        chk("R8 irq sweep", 32'(irq_o), 32'(|(expp & m)));
      end
    end

    // R6 edge sticky, W1C, zero write has no effect (rising, pin 0)
    wr(A_POL, 0); wr(A_TRIG, 32'hFF); wr(A_MASK, 0); wr(A_UNM, 1);
    pin_in = '0; step(4); wr(A_ACK, 32'hFF); step(1);
    pin_in = 8'h01; step(4);
    pin_in = 8'h00; step(4);
    rd(A_STAT, v); chk("R6 sticky", v, 1);
    chk("R8 irq from edge", 32'(irq_o), 1);
    wr(A_ACK, 32'hFE); step(1);
    rd(A_STAT, v); chk("R6 zero write no effect", v, 1);
    // R7 clear coincident with new edge: edge wins
    pin_in = 8'h01; step(2);
    wr(A_ACK, 32'h01);
    rd(A_STAT, v); chk("R7 edge beats clear", v, 1);
    wr(A_ACK, 32'h01); step(1);
    rd(A_STAT, v); chk("R6 clear", v, 0);
    step(1);
    chk("R8 irq drops", 32'(irq_o), 0);
    // R9 leaving interrupt mode drops pending
    pin_in = 8'h00; step(3); pin_in = 8'h01; step(4);
    wr(A_MODE, 0); step(1);
    rd(A_STAT, v); chk("R9 mode exit clears", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule